// File: doc/BRIEF.md
# Initiator Parity Error Reporting Unit

This unit sits beside a bus initiator and reports parity errors that the initiator sees while a target answers one of its read requests with a split response termination. Each termination shows up as a one-cycle strobe, and a flag beside it says whether a parity error was seen in that cycle. The unit then drives the active-low parity-error and system-error pulses onto the bus with the right delay. It also keeps sticky status and interrupt status bits, and raises one combined interrupt line.

The parity-error pulse follows the event after a delay that depends on the bus timing mode: a short delay in conventional timing and a longer one in extended timing. A small slot pipeline carries each accepted event to the output, so errors that arrive close together each get their own pulse. Software clears status and interrupt bits by writing ones through a strobe and two bit vectors. Every termination also produces a one-cycle hint that the read request must stay queued, because completions for it are still to come.

Top module: `init_parerr_rpt`

## Requirements
- R1: In conventional timing (`ext_mode`=0), an accepted parity event sampled in cycle N drives `perr_n` low in cycle N+2. An event is accepted when `term_vld`, `term_perr` and `cmd_perr_rsp_en` are all 1.
- R2: In extended timing (`ext_mode`=1), an accepted parity event sampled in cycle N drives `perr_n` low in cycle N+3.
- R3: When `cmd_perr_rsp_en` is 0, a parity event drives no `perr_n` or `serr_n` pulse and sets neither the master-parity status bit nor the system-error status bit.
- R4: Each accepted event gives exactly one low cycle on `perr_n`. Events in consecutive or nearly consecutive cycles of the same mode each keep their own low cycle.
- R5: The master-parity status bit `sts[1]` is set in the same cycle that `perr_n` goes low. The interrupt bit `int_sts[1]` is set with it only while `imsk_mpe` is 0.
- R6: `serr_n` goes low in the same cycle as the event's `perr_n` pulse only when `cmd_serr_en` was 1 and `xcmd_ue_rcv_en` was 0 at the event.
- R7: When `serr_n` goes low, status bit `sts[2]` is set. The interrupt bit `int_sts[2]` is set with it only while `imsk_serr` is 0.
- R8: When `serr_n` goes low and `ctl_serr_det_ie` is 1, the interrupt bit `int_sts[3]` is set. This bit uses enable-high gating, so 0 leaves it unchanged.
- R9: Every parity event (`term_vld` and `term_perr`) sets status bit `sts[0]` in the next cycle, whatever the response enable is. `int_sts[0]` is set with it only while `imsk_dpe` is 0.
- R10: Every termination (`term_vld`=1), with or without a parity error, pulses `req_hold` high for one cycle in the next cycle.
- R11: All status and interrupt bits are sticky. A cycle with `clr_we`=1 clears exactly the bits where `clr_sts`/`clr_int` hold 1. If a set and a clear of the same bit land in the same cycle, the bit stays 1.
- R12: `irq` is 1 exactly when any bit of `int_sts` is 1.
- R13: After reset, `perr_n` and `serr_n` are 1 and `sts`, `int_sts`, `irq` and `req_hold` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| term_vld | input | 1 | Split response termination strobe, one cycle |
| term_perr | input | 1 | Parity error seen with this termination |
| ext_mode | input | 1 | 1 = extended bus timing, 0 = conventional |
| cmd_perr_rsp_en | input | 1 | Parity error response enable |
| cmd_serr_en | input | 1 | System error pulse enable |
| xcmd_ue_rcv_en | input | 1 | Uncorrectable-data recover enable; 1 blocks the system error pulse |
| ctl_serr_det_ie | input | 1 | System-error-detected interrupt enable |
| imsk_mpe | input | 1 | Mask for master-parity interrupt |
| imsk_serr | input | 1 | Mask for system-error-asserted interrupt |
| imsk_dpe | input | 1 | Mask for detected-parity interrupt |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_sts | input | 3 | Status bits to clear |
| clr_int | input | 4 | Interrupt status bits to clear |
| perr_n | output | 1 | Active-low parity error pulse |
| serr_n | output | 1 | Active-low system error pulse |
| sts | output | 3 | Status: [0] detected parity, [1] master parity, [2] system error asserted |
| int_sts | output | 4 | Interrupt status: [0] detected parity, [1] master parity, [2] system error asserted, [3] system error detected |
| irq | output | 1 | OR of all interrupt status bits |
| req_hold | output | 1 | Read request stays pending |

## Verification
The bench builds the unit with the default delays of two and three cycles. With these values the slot pipeline is two stages deep, and conventional events enter at the output stage while extended ones enter one stage above it. The bench sends pairs of events one cycle apart and two cycles apart in each mode. This fills both stages at once and shows that every event keeps its own pulse at the exact expected cycle. It also times a clear write into the same cycle as a new set of the same bit.

// File: rtl/ipr_pkg.sv
package ipr_pkg;

    // One pending pulse request in the delay pipeline
    typedef struct packed {
        logic serr;
        logic vld;
    } perr_slot_t;

    // Status bit positions
    localparam int NSTS    = 3;
    localparam int STS_DPE = 0;
    localparam int STS_MPE = 1;
    localparam int STS_SA  = 2;

    // Interrupt status bit positions
    localparam int NINT    = 4;
    localparam int INT_DPE = 0;
    localparam int INT_MPE = 1;
    localparam int INT_SA  = 2;
    localparam int INT_SD  = 3;

endpackage

// File: rtl/ipr_perr_pipe.sv
module ipr_perr_pipe
    import ipr_pkg::*;
#(
    parameter int CONV_DLY = 2,
    parameter int EXT_DLY  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic push_ext,
    input  logic push_serr,
    output logic fire,
    output logic fire_serr
);
    localparam int MAX_DLY   = (EXT_DLY > CONV_DLY) ? EXT_DLY : CONV_DLY;
    localparam int DEPTH     = MAX_DLY - 1;
    localparam int CONV_SLOT = CONV_DLY - 2;
    localparam int EXT_SLOT  = EXT_DLY - 2;

    // slot_q[0] feeds the output flops; the top slot is always empty
    perr_slot_t [DEPTH:0] slot_q;
    perr_slot_t [DEPTH:0] slot_d;

    always_comb begin
        slot_d = '0;
        for (int j = 0; j < DEPTH; j++) begin
            slot_d[j] = slot_q[j+1];
            if (push && ((push_ext && (j == EXT_SLOT)) || (!push_ext && (j == CONV_SLOT)))) begin
                slot_d[j].vld  = 1'b1;
                slot_d[j].serr = slot_q[j+1].serr | push_serr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign fire      = slot_q[0].vld;
    assign fire_serr = slot_q[0].serr;

endmodule

// File: rtl/ipr_status_bank.sv
module ipr_status_bank
    import ipr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_dpe,
    input  logic            set_mpe,
    input  logic            set_sa,
    input  logic            imsk_dpe,
    input  logic            imsk_mpe,
    input  logic            imsk_sa,
    input  logic            sd_ie,
    input  logic            clr_we,
    input  logic [NSTS-1:0] clr_sts,
    input  logic [NINT-1:0] clr_int,
    output logic [NSTS-1:0] sts,
    output logic [NINT-1:0] int_sts
);
    logic [NSTS-1:0] sts_set;
    logic [NINT-1:0] int_set;

    always_comb begin
        sts_set          = '0;
        sts_set[STS_DPE] = set_dpe;
        sts_set[STS_MPE] = set_mpe;
        sts_set[STS_SA]  = set_sa;
        int_set          = '0;
        int_set[INT_DPE] = set_dpe & ~imsk_dpe;
        int_set[INT_MPE] = set_mpe & ~imsk_mpe;
        int_set[INT_SA]  = set_sa  & ~imsk_sa;
        int_set[INT_SD]  = set_sa  &  sd_ie;
    end

    // Set has priority over a same-cycle write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts     <= '0;
            int_sts <= '0;
        end else begin
            sts     <= (sts     & ~({NSTS{clr_we}} & clr_sts)) | sts_set;
            int_sts <= (int_sts & ~({NINT{clr_we}} & clr_int)) | int_set;
        end
    end

    for (genvar i = 0; i < NSTS; i++) begin : g_sts_chk
        a_r11_sts_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (sts[i] && !(clr_we && clr_sts[i])) |=> sts[i]);
        a_r11_sts_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            sts_set[i] |=> sts[i]);
    end

    for (genvar i = 0; i < NINT; i++) begin : g_int_chk
        a_r11_int_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (int_sts[i] && !(clr_we && clr_int[i])) |=> int_sts[i]);
    end

endmodule

// File: rtl/init_parerr_rpt.sv
module init_parerr_rpt
    import ipr_pkg::*;
#(
    parameter int CONV_DLY = 2,
    parameter int EXT_DLY  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            term_vld,
    input  logic            term_perr,
    input  logic            ext_mode,
    input  logic            cmd_perr_rsp_en,
    input  logic            cmd_serr_en,
    input  logic            xcmd_ue_rcv_en,
    input  logic            ctl_serr_det_ie,
    input  logic            imsk_mpe,
    input  logic            imsk_serr,
    input  logic            imsk_dpe,
    input  logic            clr_we,
    input  logic [NSTS-1:0] clr_sts,
    input  logic [NINT-1:0] clr_int,
    output logic            perr_n,
    output logic            serr_n,
    output logic [NSTS-1:0] sts,
    output logic [NINT-1:0] int_sts,
    output logic            irq,
    output logic            req_hold
);
    logic par_evt;
    logic acc_evt;
    logic serr_ok;
    logic fire;
    logic fire_serr;

    assign par_evt = term_vld & term_perr;
    assign acc_evt = par_evt & cmd_perr_rsp_en;
    assign serr_ok = cmd_serr_en & ~xcmd_ue_rcv_en;

    ipr_perr_pipe #(
        .CONV_DLY (CONV_DLY),
        .EXT_DLY  (EXT_DLY)
    ) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (acc_evt),
        .push_ext  (ext_mode),
        .push_serr (serr_ok),
        .fire      (fire),
        .fire_serr (fire_serr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perr_n   <= 1'b1;
            serr_n   <= 1'b1;
            req_hold <= 1'b0;
        end else begin
            perr_n   <= ~fire;
            serr_n   <= ~fire_serr;
            req_hold <= term_vld;
        end
    end

    ipr_status_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_dpe  (par_evt),
        .set_mpe  (fire),
        .set_sa   (fire_serr),
        .imsk_dpe (imsk_dpe),
        .imsk_mpe (imsk_mpe),
        .imsk_sa  (imsk_serr),
        .sd_ie    (ctl_serr_det_ie),
        .clr_we   (clr_we),
        .clr_sts  (clr_sts),
        .clr_int  (clr_int),
        .sts      (sts),
        .int_sts  (int_sts)
    );

    assign irq = |int_sts;

    if (CONV_DLY == 2) begin : g_conv_chk
        a_r1_conv_delay: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_evt && !ext_mode) |=> ##1 !perr_n);
    end
    if (EXT_DLY == 3) begin : g_ext_chk
        a_r2_ext_delay: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_evt && ext_mode) |=> ##2 !perr_n);
    end

    a_r5_mpe_with_perr: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> sts[STS_MPE]);
    a_r6_serr_inside_perr: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> !perr_n);
    a_r7_sa_with_serr: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_n |-> sts[STS_SA]);
    a_r8_sd_needs_serr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_sts[INT_SD]) |-> !serr_n);
    a_r9_dpe_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        par_evt |=> sts[STS_DPE]);
    a_r10_hold_after_term: assert property (@(posedge clk) disable iff (!rst_n)
        term_vld |=> req_hold);

endmodule

// File: tb/init_parerr_rpt_tb.sv
module init_parerr_rpt_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CONV_D = 2;
    localparam int EXT_D  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic term_vld = 1'b0, term_perr = 1'b0, ext_mode = 1'b0;
    logic cmd_perr_rsp_en = 1'b0, cmd_serr_en = 1'b0, xcmd_ue_rcv_en = 1'b0;
    logic ctl_serr_det_ie = 1'b0;
    logic imsk_mpe = 1'b0, imsk_serr = 1'b0, imsk_dpe = 1'b0;
    logic clr_we = 1'b0;
    logic [2:0] clr_sts = '0;
    logic [3:0] clr_int = '0;
    logic perr_n, serr_n, irq, req_hold;
    logic [2:0] sts;
    logic [3:0] int_sts;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    int q_perr[$];
    int q_serr[$];
    int q_hold[$];
    logic e_perr, e_serr, e_hold;

    init_parerr_rpt #(.CONV_DLY(CONV_D), .EXT_DLY(EXT_D)) u_dut (
        .clk(clk), .rst_n(rst_n), .term_vld(term_vld), .term_perr(term_perr),
        .ext_mode(ext_mode), .cmd_perr_rsp_en(cmd_perr_rsp_en),
        .cmd_serr_en(cmd_serr_en), .xcmd_ue_rcv_en(xcmd_ue_rcv_en),
        .ctl_serr_det_ie(ctl_serr_det_ie), .imsk_mpe(imsk_mpe),
        .imsk_serr(imsk_serr), .imsk_dpe(imsk_dpe), .clr_we(clr_we),
        .clr_sts(clr_sts), .clr_int(clr_int), .perr_n(perr_n), .serr_n(serr_n),
        .sts(sts), .int_sts(int_sts), .irq(irq), .req_hold(req_hold)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Monitor: pops expected pulse cycles and compares every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            e_perr = (q_perr.size() > 0) && (q_perr[0] == cyc);
            if (e_perr) void'(q_perr.pop_front());
            e_serr = (q_serr.size() > 0) && (q_serr[0] == cyc);
            if (e_serr) void'(q_serr.pop_front());
            e_hold = (q_hold.size() > 0) && (q_hold[0] == cyc);
            if (e_hold) void'(q_hold.pop_front());
            chk("R1/R2/R3/R4 perr_n", {7'd0, perr_n}, {7'd0, !e_perr});
            chk("R6 serr_n", {7'd0, serr_n}, {7'd0, !e_serr});
            chk("R10 req_hold", {7'd0, req_hold}, {7'd0, e_hold});
        end
    end

    // Driver: present one termination in the next cycle and push expectations
    task automatic fire(bit ext, bit par);
        int d;
        @(negedge clk);
        term_vld  = 1'b1;
        term_perr = par;
        ext_mode  = ext;
        clr_we    = 1'b0;
        q_hold.push_back(cyc + 1);
        if (par && cmd_perr_rsp_en) begin
            d = ext ? EXT_D : CONV_D;
            q_perr.push_back(cyc + d);
            if (cmd_serr_en && !xcmd_ue_rcv_en) q_serr.push_back(cyc + d);
        end
    endtask

    task automatic quiet(int n);
        repeat (n) begin
            @(negedge clk);
            term_vld  = 1'b0;
            term_perr = 1'b0;
            clr_we    = 1'b0;
        end
    endtask

    task automatic w1c(logic [2:0] s, logic [3:0] i);
        @(negedge clk);
        term_vld = 1'b0;
        term_perr = 1'b0;
        clr_we  = 1'b1;
        clr_sts = s;
        clr_int = i;
        quiet(2);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 perr_n", {7'd0, perr_n}, 8'd1);
        chk("R13 serr_n", {7'd0, serr_n}, 8'd1);
        chk("R13 sts", {5'd0, sts}, 8'd0);
        chk("R13 int_sts", {4'd0, int_sts}, 8'd0);
        chk("R13 irq", {7'd0, irq}, 8'd0);

        // Conventional timing, no system error
        cmd_perr_rsp_en = 1'b1;
        fire(0, 1); quiet(6);
        chk("R5/R9 sts conv", {5'd0, sts}, 8'h03);
        chk("R5/R9 int_sts conv", {4'd0, int_sts}, 8'h03);
        chk("R12 irq set", {7'd0, irq}, 8'd1);
        w1c(3'b111, 4'b1111);
        chk("R11 sts cleared", {5'd0, sts}, 8'd0);
        chk("R11 int cleared", {4'd0, int_sts}, 8'd0);
        chk("R12 irq clear", {7'd0, irq}, 8'd0);

        // Extended timing with system error and detected-interrupt enable
        cmd_serr_en = 1'b1; ctl_serr_det_ie = 1'b1;
        fire(1, 1); quiet(6);
        chk("R7 sts ext serr", {5'd0, sts}, 8'h07);
        chk("R7/R8 int_sts ext serr", {4'd0, int_sts}, 8'h0f);
        w1c(3'b111, 4'b1111);

        // Recover enable blocks the system error pulse
        xcmd_ue_rcv_en = 1'b1;
        fire(1, 1); quiet(6);
        chk("R6 sts recover", {5'd0, sts}, 8'h03);
        chk("R6 int_sts recover", {4'd0, int_sts}, 8'h03);
        w1c(3'b111, 4'b1111);
        xcmd_ue_rcv_en = 1'b0;

        // Response disabled: only the detected-parity bit
        cmd_perr_rsp_en = 1'b0;
        fire(0, 1); quiet(6);
        chk("R3/R9 sts no resp", {5'd0, sts}, 8'h01);
        chk("R3/R9 int_sts no resp", {4'd0, int_sts}, 8'h01);
        w1c(3'b111, 4'b1111);

        // All masks set, detected-interrupt enable off
        cmd_perr_rsp_en = 1'b1; ctl_serr_det_ie = 1'b0;
        imsk_mpe = 1'b1; imsk_serr = 1'b1; imsk_dpe = 1'b1;
        fire(0, 1); quiet(6);
        chk("R5/R7/R9 sts masked", {5'd0, sts}, 8'h07);
        chk("R5/R7/R8/R9 int masked", {4'd0, int_sts}, 8'h00);
        chk("R12 irq masked", {7'd0, irq}, 8'd0);
        // Detected-interrupt enable alone
        ctl_serr_det_ie = 1'b1;
        fire(1, 1); quiet(6);
        chk("R8 int enable high", {4'd0, int_sts}, 8'h08);
        chk("R12 irq sd only", {7'd0, irq}, 8'd1);
        w1c(3'b111, 4'b1111);
        imsk_mpe = 1'b0; imsk_serr = 1'b0; imsk_dpe = 1'b0;
        ctl_serr_det_ie = 1'b0; cmd_serr_en = 1'b0;

        // Termination without parity error
        fire(0, 0); quiet(6);
        chk("R10 no-error sts", {5'd0, sts}, 8'h00);
        chk("R10 no-error int", {4'd0, int_sts}, 8'h00);

        // Back-to-back and gapped events in each mode (R4)
        fire(1, 1); fire(1, 1); quiet(6);
        fire(0, 1); fire(0, 1); quiet(6);
        fire(1, 1); quiet(1); fire(1, 1); quiet(6);
        fire(0, 1); quiet(1); fire(0, 1); quiet(6);
        chk("R4 sts after bursts", {5'd0, sts}, 8'h03);

        // Clear and set of the same bit in one cycle (R11)
        cmd_perr_rsp_en = 1'b0;
        fire(0, 1);
        clr_we = 1'b1; clr_sts = 3'b001; clr_int = 4'b0000;
        quiet(3);
        chk("R11 set wins", {5'd0, sts}, 8'h03);
        w1c(3'b001, 4'b0000);
        chk("R11 selective clear", {5'd0, sts}, 8'h02);
        chk("R11 int untouched", {4'd0, int_sts}, 8'h03);

        quiet(4);
        chk("R4 no leftover perr", {7'd0, 1'(q_perr.size() != 0)}, 8'd0);
        done = 1;
        summary();
        $finish;
    end

endmodule